// File: doc/BRIEF.md
# SCSI Target Bus Phase Sequencer

This block owns the three phase lines (message, command/data, input/output) that a SCSI target presents to the initiator. The target's controller hands it a phase request. The block waits until the initiator's acknowledge line is idle, then moves the lines and enables the control drivers. It then counts out the bus settle time and finally raises a one-cycle ready pulse.

A request flagged as a release does not drive a phase. It turns the drivers off and drops the lines. This covers bus free and the case where another device owns the bus. The block also reports whether the synchronous transfer engine should be used for the phase now on the bus.

The settle time is counted in clock cycles derived from nanosecond parameters. It grows when the transfer direction flips and grows a great deal more when a legacy compatibility mode is on.

Top module: `scsi_phase_seq`

## Requirements
- R1: After reset the control drivers are off, all three phase lines are low, sync_mode is low, busy is low and ready is low. The current state counts as released.
- R2: A request with req_valid high while busy is low is accepted, and busy rises on the next cycle. A request made while busy is high is ignored: it changes no line and starts no second sequence.
- R3: While an accepted request waits, ack_in high with bus_reset low holds the phase lines, the driver enable and ready unchanged. The change is applied on the first clock edge at which ack_in is low.
- R4: A high bus_reset ends the acknowledge wait, so the change is applied even while ack_in is high.
- R5: For a real phase, req_phase bit 2 drives phase_msg, bit 1 drives phase_cd and bit 0 drives phase_io, and ctrl_oe goes high.
- R6: A request with req_release high switches ctrl_oe off and sets all three phase lines low. It has zero settle time: ready comes on the edge that applies the change.
- R7: A request equal to the current state (the same real phase, or release while already released) changes nothing, including sync_mode. It has zero settle time.
- R8: A change to a real phase waits SETTLE_NS (400 ns by default, rounded up to whole clocks) after the applying edge before ready.
- R9: TURN_NS (400 ns by default) is added when the new I/O bit differs from the previous one. A released state counts as I/O = 0.
- R10: With legacy_mode high, LEGACY_NS (100 µs by default) is added to the settle time of a real phase change.
- R11: Every applied change sets sync_mode high only when the new phase is data-in (code 3'b001) and sync_offset is nonzero. In every other case, including release, it sets sync_mode low.
- R12: ready is a single-cycle pulse, and busy is low in the cycle ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Phase request strobe |
| req_release | input | 1 | Request is a release of all outputs |
| req_phase | input | 3 | Requested phase code {msg, cd, io} |
| ack_in | input | 1 | Initiator acknowledge line, active high |
| bus_reset | input | 1 | Bus reset flag; ends the acknowledge wait |
| legacy_mode | input | 1 | Pre-SCSI-2 compatibility: long settle time |
| sync_offset | input | OFF_W | Negotiated synchronous offset |
| phase_msg | output | 1 | Message phase line |
| phase_cd | output | 1 | Command/data phase line |
| phase_io | output | 1 | Input/output phase line |
| ctrl_oe | output | 1 | Control line driver enable |
| sync_mode | output | 1 | Synchronous transfer selected for the current phase |
| busy | output | 1 | Request in progress; new requests ignored |
| ready | output | 1 | One-cycle pulse: phase settled |

## Verification
The hardest state to reach is an accepted request parked behind a held acknowledge. In that state a second request, a reset flag or a direction change can all meet. The stimulus raises ack_in before it issues the request and keeps it up for several cycles while it confirms that the lines and ready stay put. It then drops ack_in and times ready from that edge. A second run holds ack_in high and raises bus_reset instead, to show the wait is cut short. A separate run strobes a new request in the middle of a settle count to prove that it is ignored.

// File: rtl/scsi_phase_pkg.sv
package scsi_phase_pkg;

   typedef enum logic [1:0] {
      GS_IDLE   = 2'd0,
      GS_HOLD   = 2'd1,
      GS_SETTLE = 2'd2
   } gate_st_e;

   typedef struct packed {
      logic       rel;
      logic [2:0] code;
   } phase_req_t;

   localparam int BIT_MSG = 2;
   localparam int BIT_CD  = 1;
   localparam int BIT_IO  = 0;

   localparam logic [2:0] CODE_DATA_IN = 3'b001;

   function automatic int ns_to_cycles(input int ns, input int clk_ns);
      return (ns + clk_ns - 1) / clk_ns;
   endfunction

endpackage

// File: rtl/scsi_phase_gate.sv
module scsi_phase_gate
   import scsi_phase_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  phase_req_t req_in,
   input  logic       ack_in,
   input  logic       bus_reset,
   input  logic       expire,
   output phase_req_t held,
   output logic       apply,
   output logic       in_hold,
   output logic       busy
);

   gate_st_e   st_q;
   phase_req_t held_q;
   logic       go;

   assign go      = !ack_in || bus_reset;
   assign in_hold = (st_q == GS_HOLD);
   assign apply   = in_hold && go;
   assign busy    = (st_q != GS_IDLE);
   assign held    = held_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= GS_IDLE;
         held_q <= '0;
      end else begin
         unique case (st_q)
            GS_IDLE: begin
               if (req_valid) begin
                  held_q <= req_in;
                  st_q   <= GS_HOLD;
               end
            end
            GS_HOLD: begin
               if (go) st_q <= expire ? GS_IDLE : GS_SETTLE;
            end
            GS_SETTLE: begin
               if (expire) st_q <= GS_IDLE;
            end
            default: st_q <= GS_IDLE;
         endcase
      end
   end

   // R2: a request arriving during the settle count never restarts the hold
   a_r2_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == GS_SETTLE) |=> (st_q != GS_HOLD));

endmodule

// File: rtl/scsi_phase_delay.sv
module scsi_phase_delay #(
   parameter int CNT_W          = 14,
   parameter int BASE_CYC       = 40,
   parameter int TURN_CYC       = 40,
   parameter int LEG_CYC        = 10000,
   parameter bit LEGACY_SUPPORT = 1'b1
) (
   input  logic             same,
   input  logic             rel,
   input  logic             new_io,
   input  logic             old_io,
   input  logic             legacy_mode,
   output logic [CNT_W-1:0] delay
);

   logic [CNT_W-1:0] turn_add;
   logic [CNT_W-1:0] leg_add;

   assign turn_add = (new_io != old_io) ? CNT_W'(TURN_CYC) : '0;

   generate
      if (LEGACY_SUPPORT) begin : g_legacy
         assign leg_add = legacy_mode ? CNT_W'(LEG_CYC) : '0;
      end else begin : g_no_legacy
         assign leg_add = '0;
      end
   endgenerate

   always_comb begin
      if (same || rel) delay = '0;
      else             delay = CNT_W'(BASE_CYC) + turn_add + leg_add;
   end

endmodule

// File: rtl/scsi_phase_timer.sv
module scsi_phase_timer #(
   parameter int CNT_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] delay,
   output logic             expire,
   output logic             ready
);

   logic [CNT_W-1:0] cnt_q;
   logic             run_q;
   logic             ready_q;

   assign expire = (load && (delay == '0)) || (run_q && (cnt_q == '0));
   assign ready  = ready_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         run_q   <= 1'b0;
         ready_q <= 1'b0;
      end else begin
         ready_q <= expire;
         if (load && (delay != '0)) begin
            run_q <= 1'b1;
            cnt_q <= delay - CNT_W'(1);
         end else if (run_q) begin
            if (cnt_q == '0) run_q <= 1'b0;
            else             cnt_q <= cnt_q - CNT_W'(1);
         end
      end
   end

   // R8: the gate never loads a new count while one is still running
   a_r8_no_reload_running: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> !load);

   // R12: the ready pulse lasts one cycle
   a_r12_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
      ready_q |=> !ready_q);

endmodule

// File: rtl/scsi_phase_lines.sv
module scsi_phase_lines
   import scsi_phase_pkg::*;
#(
   parameter int OFF_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             apply,
   input  phase_req_t       held,
   input  logic [OFF_W-1:0] sync_offset,
   output logic             same,
   output logic             old_io,
   output logic             phase_msg,
   output logic             phase_cd,
   output logic             phase_io,
   output logic             ctrl_oe,
   output logic             sync_mode
);

   logic       rel_q;
   logic [2:0] code_q;
   logic       sync_q;

   assign same   = (held.rel && rel_q) ||
                   (!held.rel && !rel_q && (held.code == code_q));
   assign old_io = rel_q ? 1'b0 : code_q[BIT_IO];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rel_q  <= 1'b1;
         code_q <= '0;
         sync_q <= 1'b0;
      end else if (apply && !same) begin
         rel_q  <= held.rel;
         code_q <= held.rel ? 3'b000 : held.code;
         sync_q <= !held.rel && (held.code == CODE_DATA_IN) && (|sync_offset);
      end
   end

   assign phase_msg = code_q[BIT_MSG];
   assign phase_cd  = code_q[BIT_CD];
   assign phase_io  = code_q[BIT_IO];
   assign ctrl_oe   = !rel_q;
   assign sync_mode = sync_q;

   // R6: with the drivers off, no phase line is left high
   a_r6_released_low: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_oe |-> ({phase_msg, phase_cd, phase_io} == 3'b000));

   // R11: synchronous mode only ever accompanies a driven data-in phase
   a_r11_sync_datain: assert property (@(posedge clk) disable iff (!rst_n)
      sync_mode |-> (ctrl_oe && ({phase_msg, phase_cd, phase_io} == CODE_DATA_IN)));

endmodule

// File: rtl/scsi_phase_seq.sv
module scsi_phase_seq
   import scsi_phase_pkg::*;
#(
   parameter int CLK_NS         = 10,
   parameter int SETTLE_NS      = 400,
   parameter int TURN_NS        = 400,
   parameter int LEGACY_NS      = 100000,
   parameter bit LEGACY_SUPPORT = 1'b1,
   parameter int OFF_W          = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_release,
   input  logic [2:0]       req_phase,
   input  logic             ack_in,
   input  logic             bus_reset,
   input  logic             legacy_mode,
   input  logic [OFF_W-1:0] sync_offset,
   output logic             phase_msg,
   output logic             phase_cd,
   output logic             phase_io,
   output logic             ctrl_oe,
   output logic             sync_mode,
   output logic             busy,
   output logic             ready
);

   localparam int BASE_CYC = ns_to_cycles(SETTLE_NS, CLK_NS);
   localparam int TURN_CYC = ns_to_cycles(TURN_NS, CLK_NS);
   localparam int LEG_CYC  = LEGACY_SUPPORT ? ns_to_cycles(LEGACY_NS, CLK_NS) : 0;
   localparam int MAX_CYC  = BASE_CYC + TURN_CYC + LEG_CYC;
   localparam int CNT_W    = $clog2(MAX_CYC + 1);

   generate
      if (CLK_NS < 1)   begin : g_bad_clk    $error("CLK_NS must be positive");    end
      if (SETTLE_NS < 1) begin : g_bad_settle $error("SETTLE_NS must be positive"); end
      if (TURN_NS < 0)  begin : g_bad_turn   $error("TURN_NS must not be negative"); end
      if (LEGACY_NS < 0) begin : g_bad_leg   $error("LEGACY_NS must not be negative"); end
      if (OFF_W < 1)    begin : g_bad_off    $error("OFF_W must be at least 1");   end
   endgenerate

   phase_req_t       req_in;
   phase_req_t       held;
   logic             apply;
   logic             in_hold;
   logic             expire;
   logic             same;
   logic             old_io;
   logic [CNT_W-1:0] delay;

   assign req_in.rel  = req_release;
   assign req_in.code = req_phase;

   scsi_phase_gate u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_in    (req_in),
      .ack_in    (ack_in),
      .bus_reset (bus_reset),
      .expire    (expire),
      .held      (held),
      .apply     (apply),
      .in_hold   (in_hold),
      .busy      (busy)
   );

   scsi_phase_lines #(.OFF_W(OFF_W)) u_lines (
      .clk         (clk),
      .rst_n       (rst_n),
      .apply       (apply),
      .held        (held),
      .sync_offset (sync_offset),
      .same        (same),
      .old_io      (old_io),
      .phase_msg   (phase_msg),
      .phase_cd    (phase_cd),
      .phase_io    (phase_io),
      .ctrl_oe     (ctrl_oe),
      .sync_mode   (sync_mode)
   );

   scsi_phase_delay #(
      .CNT_W          (CNT_W),
      .BASE_CYC       (BASE_CYC),
      .TURN_CYC       (TURN_CYC),
      .LEG_CYC        (LEG_CYC),
      .LEGACY_SUPPORT (LEGACY_SUPPORT)
   ) u_delay (
      .same        (same),
      .rel         (held.rel),
      .new_io      (held.code[BIT_IO]),
      .old_io      (old_io),
      .legacy_mode (legacy_mode),
      .delay       (delay)
   );

   scsi_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (apply),
      .delay  (delay),
      .expire (expire),
      .ready  (ready)
   );

   // R3: a held acknowledge freezes the bus-facing lines
   a_r3_ack_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (in_hold && ack_in && !bus_reset) |=>
         ($stable({phase_msg, phase_cd, phase_io, ctrl_oe}) && !ready));

   // R12: busy and ready never overlap
   a_r12_ready_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> !busy);

endmodule

// File: tb/scsi_phase_seq_tb.sv
module scsi_phase_seq_tb;

   localparam int CLK_PERIOD = 10;
   localparam int OFF_W      = 5;
   localparam int LIMIT      = 20000;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req_valid = 1'b0;
   logic             req_release = 1'b0;
   logic [2:0]       req_phase = 3'b000;
   logic             ack_in = 1'b0;
   logic             bus_reset = 1'b0;
   logic             legacy_mode = 1'b0;
   logic [OFF_W-1:0] sync_offset = '0;
   logic             phase_msg, phase_cd, phase_io, ctrl_oe, sync_mode, busy, ready;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   scsi_phase_seq #(.CLK_NS(CLK_PERIOD), .OFF_W(OFF_W)) u_dut (
      .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_release (req_release),
      .req_phase (req_phase), .ack_in (ack_in), .bus_reset (bus_reset),
      .legacy_mode (legacy_mode), .sync_offset (sync_offset),
      .phase_msg (phase_msg), .phase_cd (phase_cd), .phase_io (phase_io),
      .ctrl_oe (ctrl_oe), .sync_mode (sync_mode), .busy (busy), .ready (ready)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic chk_lines(input string tag, input logic [2:0] el,
                            input logic eoe, input logic es);
      chk({phase_msg, phase_cd, phase_io} == el, tag, "phase lines",
          {phase_msg, phase_cd, phase_io}, el);
      chk(ctrl_oe == eoe, tag, "ctrl_oe", ctrl_oe, eoe);
      chk(sync_mode == es, tag, "sync_mode", sync_mode, es);
   endtask

   // Issue a request and count posedges until ready (zero settle gives 2)
   task automatic do_req(input string tag, input logic rel, input logic [2:0] code,
                         input int exp_n, input logic [2:0] el, input logic eoe,
                         input logic es, input int ign_at);
      int n = 0;
      @(negedge clk);
      req_release = rel; req_phase = code; req_valid = 1'b1;
      while (n < LIMIT) begin
         @(posedge clk); n++;
         @(negedge clk);
         if (n == 1) req_valid = 1'b0;
         if (ign_at != 0 && n == ign_at) begin
            req_release = 1'b0; req_phase = 3'b100; req_valid = 1'b1;
         end else if (ign_at != 0 && n == ign_at + 1) begin
            req_valid = 1'b0;
         end
         if (ready) break;
      end
      chk(n == exp_n, tag, "cycles to ready", n, exp_n);
      chk(busy == 1'b0, "R12", "busy during ready", busy, 0);
      chk_lines(tag, el, eoe, es);
      @(negedge clk);
      chk(ready == 1'b0, "R12", "ready second cycle", ready, 0);
   endtask

   task automatic t_reset();
      chk_lines("R1", 3'b000, 1'b0, 1'b0);
      chk(busy == 1'b0, "R1", "busy", busy, 0);
      chk(ready == 1'b0, "R1", "ready", ready, 0);
   endtask

   task automatic t_busy_ignore();
      // R2: STATUS (011) from MSG_IN, strobe 100 mid-count
      do_req("R2", 1'b0, 3'b011, 42, 3'b011, 1'b1, 1'b0, 5);
      repeat (3) @(negedge clk);
      chk(busy == 1'b0, "R2", "busy after ignored req", busy, 0);
      chk({phase_msg, phase_cd, phase_io} == 3'b011, "R2", "lines after ignored req",
          {phase_msg, phase_cd, phase_io}, 3'b011);
   endtask

   task automatic t_ack_hold();
      int m = 0;
      @(negedge clk);
      ack_in = 1'b1;
      req_release = 1'b0; req_phase = 3'b000; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         chk(ready == 1'b0, "R3", "ready during ack", ready, 0);
         chk({phase_msg, phase_cd, phase_io} == 3'b011, "R3", "lines during ack",
             {phase_msg, phase_cd, phase_io}, 3'b011);
      end
      chk(busy == 1'b1, "R3", "busy during ack", busy, 1);
      ack_in = 1'b0;
      while (m < LIMIT) begin
         @(posedge clk); m++;
         @(negedge clk);
         if (ready) break;
      end
      chk(m == 81, "R3", "cycles from ack drop", m, 81);
      chk_lines("R3", 3'b000, 1'b1, 1'b0);
   endtask

   task automatic t_bus_reset();
      @(negedge clk);
      ack_in = 1'b1; bus_reset = 1'b1;
      do_req("R4", 1'b1, 3'b000, 2, 3'b000, 1'b0, 1'b0, 0);
      ack_in = 1'b0; bus_reset = 1'b0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      // R7: release while already released
      do_req("R7", 1'b1, 3'b000, 2, 3'b000, 1'b0, 1'b0, 0);
      // R5 R8 R9: COMMAND from released, released counts as io 0
      do_req("R5", 1'b0, 3'b010, 42, 3'b010, 1'b1, 1'b0, 0);
      // R9: DATA_IN with io flip, offset zero -> R11 async
      do_req("R9", 1'b0, 3'b001, 82, 3'b001, 1'b1, 1'b0, 0);
      // R7: same phase, offset now nonzero, sync stays low
      sync_offset = 5'd5;
      do_req("R7", 1'b0, 3'b001, 2, 3'b001, 1'b1, 1'b0, 0);
      do_req("R9", 1'b0, 3'b000, 82, 3'b000, 1'b1, 1'b0, 0);
      // R11: DATA_IN with nonzero offset
      do_req("R11", 1'b0, 3'b001, 82, 3'b001, 1'b1, 1'b1, 0);
      // R8: MSG_IN, no io flip, sync drops
      do_req("R8", 1'b0, 3'b111, 42, 3'b111, 1'b1, 1'b0, 0);
      t_busy_ignore();
      t_ack_hold();
      t_bus_reset();
      // R10: legacy settle time
      legacy_mode = 1'b1;
      do_req("R10", 1'b0, 3'b010, 10042, 3'b010, 1'b1, 1'b0, 0);
      do_req("R10", 1'b0, 3'b001, 10082, 3'b001, 1'b1, 1'b1, 0);
      legacy_mode = 1'b0;
      // R6: release from a driven data-in phase clears sync too
      do_req("R6", 1'b1, 3'b101, 2, 3'b000, 1'b0, 1'b0, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule